// File: doc/BRIEF.md
# Color Register Block Write Unit

This unit provides the graphics extensions of a synchronous graphics DRAM command front end. It holds a color register and can write one stored color into a whole aligned group of eight columns with a single command. All control inputs are sampled on the rising clock edge. A mode-register-set encoding issued with the special-function input `dsf` high loads the color register from the data bus. The same encoding with `dsf` low is passed on as a pulse for the normal mode register.

A write command with `dsf` high is a block write. The low eight data bits select which of the eight columns in the group are written. Each selected column receives the stored color, and the byte lanes are gated by the `dqm` mask. A write with `dsf` low is an ordinary single-column write of the bus data. The outputs are registered and drive a behavioural array model: a column-strobe vector, a column-group address, the write data and byte enables. Every command finishes in one cycle, so a new command can be taken on every clock.

Top module: `sgfx_blockwrite`

## Requirements
- R1: After reset, `col_we`, `byte_en` and `mode_ld` are all zero and the color register holds zero, so a block write issued before any color load writes zero.
- R2: The command encoding cs_n=0, ras_n=0, cas_n=0, we_n=0 with dsf=1 loads `dq` into the color register. Any later block write uses that value, and the load cycle raises no column strobe.
- R3: The same encoding with dsf=0 drives `mode_ld` high for exactly the cycle after the command edge, raises no column strobe and leaves the color register unchanged.
- R4: A write command (cs_n=0, ras_n=1, cas_n=0, we_n=0) with dsf=1 is a block write. On the next cycle, `col_we[c]` equals `dq[c]` for c=0..7 and `wr_data` equals the color register.
- R5: A block write ignores `col_addr[2:0]`: `col_grp` equals `col_addr[COL_W-1:3]`, and strobe bit c addresses column 8*col_grp+c.
- R6: For both write types, `byte_en[l]` equals the inverse of `dqm[l]`, and lane l is bits 8l+7..8l of the word. A lane whose mask bit is high stays unwritten in every selected column.
- R7: A write command with dsf=0 raises exactly the one strobe `col_we[col_addr[2:0]]`, with `wr_data` equal to `dq`.
- R8: Outputs follow each command by one cycle. Commands on consecutive edges give results on consecutive cycles, and a cycle with no command gives all strobes low and `mode_ld` low.
- R9: With cs_n=1, no command is taken whatever the other inputs are. There are no strobes and no mode pulse, and the color is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write enable command bit |
| dsf | input | 1 | Special-function select |
| col_addr | input | COL_W | Column address |
| dq | input | DATA_W | Data bus: color, column mask or write data |
| dqm | input | DATA_W/8 | Per-byte mask, high means do not write |
| col_we | output | NCOL | Column write strobes within the group |
| col_grp | output | COL_W-3 | Aligned column-group address |
| wr_data | output | DATA_W | Word to write into the strobed columns |
| byte_en | output | DATA_W/8 | Byte-lane write enables |
| mode_ld | output | 1 | Normal mode register load pulse |

## Verification
The hardest case to reach is the full interaction between the column mask and the byte mask under one stored color. A partial byte write must be seen to keep the other lanes of a word that an earlier color wrote. The bench sweeps all 256 column masks against all 16 byte masks, with random addresses whose low bits are set. It reloads the color every 256 writes and compares each touched group of an array model against an arithmetic reference. Deselected and normal mode-register cycles are placed between color loads and block writes, so that any unwanted change to the color shows up in a later write.

// File: rtl/sgfx_pkg.sv
package sgfx_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_MRS   = 2'd1,
    CMD_WRITE = 2'd2
  } sgfx_cmd_e;

  function automatic sgfx_cmd_e sgfx_decode(input logic cs_n, input logic ras_n,
                                            input logic cas_n, input logic we_n);
    if (cs_n) return CMD_NONE;
    case ({ras_n, cas_n, we_n})
      3'b000:  return CMD_MRS;
      3'b100:  return CMD_WRITE;
      default: return CMD_NONE;
    endcase
  endfunction

  // Active-high lane enable from an active-high mask bit.
  function automatic logic lane_enable(input logic mask_bit);
    return ~mask_bit;
  endfunction

endpackage

// File: rtl/sgfx_cmd_dec.sv
module sgfx_cmd_dec
  import sgfx_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic dsf,
  output logic ld_color,
  output logic ld_mode,
  output logic blk_wr,
  output logic norm_wr
);
  sgfx_cmd_e cmd;

  always_comb begin
    cmd      = sgfx_decode(cs_n, ras_n, cas_n, we_n);
    ld_color = (cmd == CMD_MRS)   &&  dsf;
    ld_mode  = (cmd == CMD_MRS)   && !dsf;
    blk_wr   = (cmd == CMD_WRITE) &&  dsf;
    norm_wr  = (cmd == CMD_WRITE) && !dsf;
  end
endmodule

// File: rtl/sgfx_color_reg.sv
module sgfx_color_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_color,
  input  logic [DATA_W-1:0] dq,
  output logic [DATA_W-1:0] color_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        color_q <= '0;
    else if (ld_color) color_q <= dq;
  end

  p_color_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_color |=> $stable(color_q));
endmodule

// File: rtl/sgfx_strobe_gen.sv
module sgfx_strobe_gen
  import sgfx_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int DATA_W = 32,
  parameter int NCOL   = 8,
  localparam int LANES = DATA_W / 8,
  localparam int SEL_W = $clog2(NCOL),
  localparam int GRP_W = COL_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_wr,
  input  logic              norm_wr,
  input  logic              ld_mode,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [DATA_W-1:0] dq,
  input  logic [LANES-1:0]  dqm,
  input  logic [DATA_W-1:0] color_q,
  output logic [NCOL-1:0]   col_we,
  output logic [GRP_W-1:0]  col_grp,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  byte_en,
  output logic              mode_ld
);
  logic [NCOL-1:0]  we_d;
  logic [LANES-1:0] be_d;
  logic [SEL_W-1:0] col_sel;
  logic             any_wr;

  assign col_sel = col_addr[SEL_W-1:0];
  assign any_wr  = blk_wr | norm_wr;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign we_d[c] = blk_wr ? dq[c] : (norm_wr && (col_sel == SEL_W'(c)));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be_d[l] = any_wr && lane_enable(dqm[l]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_we  <= '0;
      col_grp <= '0;
      wr_data <= '0;
      byte_en <= '0;
      mode_ld <= 1'b0;
    end else begin
      col_we  <= we_d;
      col_grp <= col_addr[COL_W-1:SEL_W];
      wr_data <= blk_wr ? color_q : dq;
      byte_en <= be_d;
      mode_ld <= ld_mode;
    end
  end

  p_blk_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_wr |=> (col_we == $past(dq[NCOL-1:0])));
  p_norm_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    norm_wr |=> $onehot(col_we));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> (col_we == '0) && (byte_en == '0));
  p_mode_no_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ld |-> (col_we == '0));
endmodule

// File: rtl/sgfx_blockwrite.sv
module sgfx_blockwrite #(
  parameter int COL_W  = 9,
  parameter int DATA_W = 32,
  parameter int NCOL   = 8,
  localparam int LANES = DATA_W / 8,
  localparam int SEL_W = $clog2(NCOL),
  localparam int GRP_W = COL_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              dsf,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [DATA_W-1:0] dq,
  input  logic [LANES-1:0]  dqm,
  output logic [NCOL-1:0]   col_we,
  output logic [GRP_W-1:0]  col_grp,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  byte_en,
  output logic              mode_ld
);
  logic ld_color, ld_mode, blk_wr, norm_wr;
  logic [DATA_W-1:0] color_q;

  sgfx_cmd_dec u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dsf(dsf),
    .ld_color(ld_color), .ld_mode(ld_mode), .blk_wr(blk_wr), .norm_wr(norm_wr)
  );

  sgfx_color_reg #(.DATA_W(DATA_W)) u_color (
    .clk(clk), .rst_n(rst_n), .ld_color(ld_color), .dq(dq), .color_q(color_q)
  );

  sgfx_strobe_gen #(.COL_W(COL_W), .DATA_W(DATA_W), .NCOL(NCOL)) u_strobe (
    .clk(clk), .rst_n(rst_n), .blk_wr(blk_wr), .norm_wr(norm_wr),
    .ld_mode(ld_mode), .col_addr(col_addr), .dq(dq), .dqm(dqm),
    .color_q(color_q), .col_we(col_we), .col_grp(col_grp),
    .wr_data(wr_data), .byte_en(byte_en), .mode_ld(mode_ld)
  );

  p_one_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (col_we == '0) && !mode_ld);
endmodule

// File: tb/sgfx_blockwrite_tb.sv
module sgfx_blockwrite_tb;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 6;
  localparam int NWORD = 1 << COL_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
  logic [COL_W-1:0] col_addr = '0;
  logic [31:0] dq = '0;
  logic [3:0]  dqm = '0;
  logic [7:0]  col_we;
  logic [COL_W-4:0] col_grp;
  logic [31:0] wr_data;
  logic [3:0]  byte_en;
  logic        mode_ld;

  logic [31:0] arr [NWORD];
  logic [31:0] refm [NWORD];
  logic [31:0] ref_color;
  int errors = 0, checks = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgfx_blockwrite #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dsf(dsf), .col_addr(col_addr), .dq(dq), .dqm(dqm),
    .col_we(col_we), .col_grp(col_grp), .wr_data(wr_data),
    .byte_en(byte_en), .mode_ld(mode_ld)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Array model: absorb the outputs registered at the last edge.
  task automatic absorb();
    for (int c = 0; c < 8; c++)
      if (col_we[c])
        for (int l = 0; l < 4; l++)
          if (byte_en[l]) arr[{col_grp, 3'(c)}][8*l +: 8] = wr_data[8*l +: 8];
  endtask

  task automatic drive(input logic cs, input logic r, input logic c, input logic w,
                       input logic f, input logic [COL_W-1:0] a,
                       input logic [31:0] d, input logic [3:0] m);
    cs_n = cs; ras_n = r; cas_n = c; we_n = w; dsf = f; col_addr = a; dq = d; dqm = m;
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, '0, '0);
  endtask

  // Issue one command at a negedge, idle at the next negedge, absorb result.
  task automatic issue(input logic cs, input logic r, input logic c, input logic w,
                       input logic f, input logic [COL_W-1:0] a,
                       input logic [31:0] d, input logic [3:0] m);
    @(negedge clk); drive(cs, r, c, w, f, a, d, m);
    @(negedge clk); absorb(); idle();
  endtask

  // Reference for a block write.
  task automatic ref_block(input logic [COL_W-1:0] a, input logic [7:0] msk, input logic [3:0] m);
    for (int c = 0; c < 8; c++)
      if (msk[c])
        for (int l = 0; l < 4; l++)
          if (!m[l]) refm[(int'(a) / 8) * 8 + c][8*l +: 8] = ref_color[8*l +: 8];
  endtask

  task automatic cmp_group(input logic [COL_W-1:0] a, input string tag);
    for (int c = 0; c < 8; c++) begin
      int idx = (int'(a) / 8) * 8 + c;
      chk(arr[idx] === refm[idx], tag, 64'(arr[idx]), 64'(refm[idx]));
    end
  endtask

  initial begin
    while (1) begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < NWORD; i++) begin arr[i] = '0; refm[i] = '0; end
    ref_color = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(col_we == 0 && byte_en == 0 && !mode_ld, "R1 reset outputs", 64'({col_we, byte_en, mode_ld}), 0);

    // R1: block write before any load writes zero
    for (int i = 0; i < NWORD; i++) begin arr[i] = 32'hFFFF_FFFF; refm[i] = 32'hFFFF_FFFF; end
    issue(0, 1, 0, 0, 1, 6'd8, 32'h0000_00FF, 4'h0);
    ref_block(6'd8, 8'hFF, 4'h0);
    cmp_group(6'd8, "R1 zero color");

    // R2: color load, no strobes
    @(negedge clk); drive(0, 0, 0, 0, 1, '0, 32'hA5C3_1E77, 4'h0);
    @(negedge clk);
    chk(col_we == 0 && !mode_ld, "R2 load no strobe", 64'(col_we), 0); idle();
    ref_color = 32'hA5C3_1E77;

    // R3: normal mode set pulses mode_ld, color kept
    @(negedge clk); drive(0, 0, 0, 0, 0, '0, 32'h1234_5678, 4'h0);
    @(negedge clk);
    chk(mode_ld === 1'b1 && col_we == 0, "R3 mode pulse", 64'({mode_ld, col_we}), 64'h100); idle();
    @(negedge clk);
    chk(mode_ld === 1'b0, "R3 pulse one cycle", 64'(mode_ld), 0);

    // R9: deselected load attempt
    issue(1, 0, 0, 0, 1, '0, 32'hDEAD_BEEF, 4'h0);
    chk(col_we == 0 && !mode_ld, "R9 deselect", 64'(col_we), 0);
    // R4/R5: block write with low address bits set
    @(negedge clk); drive(0, 1, 0, 0, 1, 6'd23, 32'h0000_0081, 4'h0);
    @(negedge clk);
    chk(col_we == 8'h81, "R4 strobes", 64'(col_we), 64'h81);
    chk(wr_data == ref_color, "R4 R3 R9 color kept", 64'(wr_data), 64'(ref_color));
    chk(col_grp == 3'd2, "R5 group", 64'(col_grp), 2);
    absorb(); idle();
    ref_block(6'd23, 8'h81, 4'h0);
    cmp_group(6'd23, "R5 aligned group");

    // R7: normal write
    @(negedge clk); drive(0, 1, 0, 0, 0, 6'd45, 32'h0BAD_F00D, 4'h6);
    @(negedge clk);
    chk(col_we == 8'h20, "R7 single strobe", 64'(col_we), 64'h20);
    chk(wr_data == 32'h0BAD_F00D, "R7 data", 64'(wr_data), 64'h0BADF00D);
    chk(byte_en == 4'h9, "R6 normal lanes", 64'(byte_en), 9);
    absorb(); idle();
    refm[45][7:0] = 8'h0D; refm[45][31:24] = 8'h0B;
    cmp_group(6'd45, "R7 array");

    // R8: back-to-back block writes
    @(negedge clk); drive(0, 1, 0, 0, 1, 6'd0, 32'h0000_0003, 4'h0);
    @(negedge clk);
    chk(col_we == 8'h03, "R8 first", 64'(col_we), 3); absorb();
    drive(0, 1, 0, 0, 1, 6'd9, 32'h0000_00C0, 4'h8);
    @(negedge clk);
    chk(col_we == 8'hC0 && col_grp == 3'd1, "R8 second", 64'({col_grp, col_we}), 64'h1C0);
    chk(byte_en == 4'h7, "R6 block lanes", 64'(byte_en), 7);
    absorb(); idle();
    @(negedge clk);
    chk(col_we == 0 && byte_en == 0, "R8 idle quiet", 64'({col_we, byte_en}), 0);
    ref_block(6'd0, 8'h03, 4'h0); ref_block(6'd9, 8'hC0, 4'h8);
    cmp_group(6'd0, "R8 array a"); cmp_group(6'd9, "R8 array b");

    // Sweep: all column masks against all byte masks (R4 R5 R6 R2)
    for (int m = 0; m < 16; m++) begin
      logic [31:0] col = $urandom;
      issue(0, 0, 0, 0, 1, '0, col, 4'h0);
      ref_color = col;
      for (int k = 0; k < 256; k++) begin
        logic [COL_W-1:0] a = COL_W'($urandom);
        issue(0, 1, 0, 0, 1, a, {$urandom, 8'(k)} , 4'(m));
        ref_block(a, 8'(k), 4'(m));
        cmp_group(a, "R6 sweep");
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule